// File: doc/BRIEF.md
# Serial Port Register Front-End with Receive FIFO

This block sits between a host register bus and a byte-level serializer. The host programs two mode registers, issues commands, reads status and interrupt flags, writes bytes for transmission and pops received bytes. The serializer side is a byte stream in each direction plus a line-break event input. Bit timing, baud generation and parity are handled elsewhere.

The mode registers share one offset. A pointer selects which one is reached, and it moves to the second register by itself after the first write. A command write carries three fields that are applied in a fixed order: first a miscellaneous action, then a transmitter action, then a receiver action. Received bytes go into a small FIFO. A break event pushes a zero byte even when the FIFO is full, in which case it replaces the newest entry. A single interrupt line combines the interrupt flags through a mask.

Top module: `uart_regfront`

## Requirements
- R1: After reset, status (offset 0x04) reads 0x08 (transmitter-empty only), the interrupt flags (offset 0x14) read 0, both mode registers read 0, irq_o is low and rx_ready_o is low.
- R2: A write at offset 0x00 stores into the mode register that the pointer selects, and then the pointer selects the second mode register. A read at 0x00 returns the selected register. A command with bits 6:4 = 1 points back at the first mode register.
- R3: Command bits 3:2 control the transmitter and bits 1:0 control the receiver. In each field, 1 enables, 2 disables, and 0 and 3 have no effect. Status bit 2 equals the transmitter enable. rx_ready_o is high exactly when the receiver is enabled and the FIFO holds fewer than 4 bytes.
- R4: The FIFO holds 4 bytes. A read at 0x0C returns the oldest byte and removes it, and a read of an empty FIFO returns 0. Status bit 0 is set when the FIFO is not empty, and status bit 1 is set when it holds 4 bytes.
- R5: A byte offered on rx_valid_i is accepted only when the receiver is enabled and the FIFO is not full. Otherwise the FIFO contents do not change.
- R6: A command with bits 6:4 = 2 disables the receiver and empties the FIFO. A command with bits 6:4 = 3 disables the transmitter and sets transmitter-empty (status bit 3).
- R7: A write at 0x0C with the transmitter enabled puts the byte on tx_data_o with tx_valid_o high for one cycle, starting in the next cycle, and leaves status bit 3 set. With the transmitter disabled, the write clears bit 3 and holds the byte until a transmitter-enable command sends it.
- R8: The interrupt flags read at 0x14 are: bit 0 = transmitter enable; bit 1 = FIFO full when bit 6 of the first mode register is set, otherwise FIFO not empty; bit 2 = break seen. A write at 0x14 sets the mask, and irq_o is high exactly when the flags ANDed with the mask are nonzero.
- R9: brk_i sets interrupt bit 2 and pushes a 0x00 byte, even when the receiver is disabled. When the FIFO is full, the zero replaces the newest entry. A command with bits 6:4 = 5 clears bit 2.
- R10: Writes at offsets 0x04 and 0x10 have no effect. Status bits 7:4 and reads at unused offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (pops the FIFO at 0x0C) |
| reg_addr_i | input | AW | Register byte offset |
| reg_wdata_i | input | DW | Write data |
| reg_rdata_o | output | DW | Read data, combinational from the current state |
| rx_valid_i | input | 1 | Received byte offered |
| rx_data_i | input | DW | Received byte |
| rx_ready_o | output | 1 | Receiver can accept a byte |
| brk_i | input | 1 | Line-break event |
| tx_valid_o | output | 1 | Transmit byte valid, one-cycle pulse |
| tx_data_o | output | DW | Transmit byte |
| irq_o | output | 1 | Interrupt request |

## Verification
Every register write, pop, push and break takes effect at the rising edge where its strobe is sampled. Read data is combinational from the state, so a read shows the result of the previous edge with no wait cycle. tx_valid_o, rx_ready_o and irq_o reflect that same edge. The bench drives inputs on the falling edge and checks read data shortly after that falling edge. At every falling edge it compares irq_o, rx_ready_o and the transmit handshake with a behavioural model that it advanced at the preceding rising edge.

// File: rtl/uart_rf_pkg.sv
`timescale 1ns/1ps
package uart_rf_pkg;
  localparam int unsigned OFS_MODE = 'h00;
  localparam int unsigned OFS_STAT = 'h04;
  localparam int unsigned OFS_CMD  = 'h08;
  localparam int unsigned OFS_DATA = 'h0C;
  localparam int unsigned OFS_AUX  = 'h10;
  localparam int unsigned OFS_INT  = 'h14;

  localparam int unsigned RXINT_SEL_BIT = 6;

  typedef enum logic [2:0] {
    MISC_NOP, MISC_PTR_RST, MISC_RX_RST, MISC_TX_RST,
    MISC_ERR_RST, MISC_BRK_CLR, MISC_BRK_ON, MISC_BRK_OFF
  } misc_cmd_e;

  typedef enum logic [1:0] {FLD_NOP, FLD_ON, FLD_OFF, FLD_RSVD} en_cmd_e;
endpackage

// File: rtl/uart_rx_fifo.sv
`timescale 1ns/1ps
module uart_rx_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [DW-1:0]    pdata_i,
  input  logic             pop_i,
  input  logic             flush_i,
  output logic [DW-1:0]    head_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0]    mem_q [DEPTH];
  logic [CNT_W-1:0] cnt_q, base;
  logic             pop_ok, at_cap, grow;
  logic [IW-1:0]    wr_idx;

  assign pop_ok = pop_i && (cnt_q != '0);
  assign base   = cnt_q - CNT_W'(pop_ok);
  assign at_cap = (base == CNT_W'(DEPTH));
  // full with no pop: the newest slot is overwritten
  assign wr_idx = at_cap ? IW'(DEPTH - 1) : IW'(base);
  assign grow   = push_i && !at_cap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (flush_i) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= base + CNT_W'(grow);
      for (int i = 0; i < DEPTH - 1; i++)
        if (pop_ok) mem_q[i] <= mem_q[i+1];
      if (push_i) mem_q[wr_idx] <= pdata_i;
    end
  end

  assign head_o = mem_q[0];
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/uart_tx_hold.sv
`timescale 1ns/1ps
module uart_tx_hold #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          buf_wr_i,
  input  logic [DW-1:0] buf_data_i,
  input  logic          en_i,
  input  logic          flush_i,
  input  logic          kick_i,
  output logic          empty_o,
  output logic          tx_valid_o,
  output logic [DW-1:0] tx_data_o
);
  logic          empty_q, valid_q, empty_mid, send;
  logic [DW-1:0] hold_q;

  assign empty_mid = flush_i | empty_q;
  assign send      = buf_wr_i ? en_i : (kick_i & ~empty_mid);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      empty_q <= 1'b1;
      valid_q <= 1'b0;
      hold_q  <= '0;
    end else begin
      valid_q <= send;
      if (buf_wr_i) hold_q <= buf_data_i;
      empty_q <= buf_wr_i ? en_i : (empty_mid | send);
    end
  end

  assign empty_o    = empty_q;
  assign tx_valid_o = valid_q;
  assign tx_data_o  = hold_q;
endmodule

// File: rtl/uart_regfront.sv
`timescale 1ns/1ps
module uart_regfront
  import uart_rf_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  parameter int AW    = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic          reg_re_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          rx_valid_i,
  input  logic [DW-1:0] rx_data_i,
  output logic          rx_ready_o,
  input  logic          brk_i,
  output logic          tx_valid_o,
  output logic [DW-1:0] tx_data_o,
  output logic          irq_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DW-1:0]    mode_q [2];
  logic             ptr_q, tx_en_q, rx_en_q, dbrk_q;
  logic [DW-1:0]    imask_q;
  logic             wr_mode, wr_cmd, wr_data, wr_int, rd_data;
  misc_cmd_e        misc;
  en_cmd_e          txf, rxf;
  logic             tx_en_d, rx_en_d, tx_rst, rx_rst, kick;
  logic             push, tx_empty;
  logic [DW-1:0]    pdata, head;
  logic [CNT_W-1:0] rx_cnt;
  logic             rx_any, rx_full;
  logic [DW-1:0]    stat, isr;

  assign wr_mode = reg_we_i && (reg_addr_i == AW'(OFS_MODE));
  assign wr_cmd  = reg_we_i && (reg_addr_i == AW'(OFS_CMD));
  assign wr_data = reg_we_i && (reg_addr_i == AW'(OFS_DATA));
  assign wr_int  = reg_we_i && (reg_addr_i == AW'(OFS_INT));
  assign rd_data = reg_re_i && (reg_addr_i == AW'(OFS_DATA));

  assign misc = misc_cmd_e'(reg_wdata_i[6:4]);
  assign txf  = en_cmd_e'(reg_wdata_i[3:2]);
  assign rxf  = en_cmd_e'(reg_wdata_i[1:0]);

  // misc field first, then transmitter, then receiver
  always_comb begin
    tx_en_d = tx_en_q;
    rx_en_d = rx_en_q;
    tx_rst  = 1'b0;
    rx_rst  = 1'b0;
    kick    = 1'b0;
    if (wr_cmd) begin
      if (misc == MISC_RX_RST) begin rx_rst = 1'b1; rx_en_d = 1'b0; end
      if (misc == MISC_TX_RST) begin tx_rst = 1'b1; tx_en_d = 1'b0; end
      case (txf)
        FLD_ON:  begin tx_en_d = 1'b1; kick = 1'b1; end
        FLD_OFF: tx_en_d = 1'b0;
        default: ;
      endcase
      case (rxf)
        FLD_ON:  rx_en_d = 1'b1;
        FLD_OFF: rx_en_d = 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q[0] <= '0;
      mode_q[1] <= '0;
      ptr_q     <= 1'b0;
      tx_en_q   <= 1'b0;
      rx_en_q   <= 1'b0;
      dbrk_q    <= 1'b0;
      imask_q   <= '0;
    end else begin
      tx_en_q <= tx_en_d;
      rx_en_q <= rx_en_d;
      if (wr_mode) begin
        mode_q[ptr_q] <= reg_wdata_i;
        ptr_q         <= 1'b1;
      end else if (wr_cmd && misc == MISC_PTR_RST) begin
        ptr_q <= 1'b0;
      end
      if (brk_i) dbrk_q <= 1'b1;
      else if (wr_cmd && misc == MISC_BRK_CLR) dbrk_q <= 1'b0;
      if (wr_int) imask_q <= reg_wdata_i;
    end
  end

  assign rx_ready_o = rx_en_q && (rx_cnt != CNT_W'(DEPTH));
  assign push       = brk_i | (rx_valid_i & rx_ready_o);
  assign pdata      = brk_i ? '0 : rx_data_i;

  uart_rx_fifo #(.DW(DW), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .pdata_i (pdata),
    .pop_i   (rd_data),
    .flush_i (rx_rst),
    .head_o  (head),
    .cnt_o   (rx_cnt)
  );

  uart_tx_hold #(.DW(DW)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .buf_wr_i   (wr_data),
    .buf_data_i (reg_wdata_i),
    .en_i       (tx_en_q),
    .flush_i    (tx_rst),
    .kick_i     (kick),
    .empty_o    (tx_empty),
    .tx_valid_o (tx_valid_o),
    .tx_data_o  (tx_data_o)
  );

  assign rx_any  = (rx_cnt != '0);
  assign rx_full = (rx_cnt == CNT_W'(DEPTH));

  always_comb begin
    stat    = '0;
    stat[0] = rx_any;
    stat[1] = rx_full;
    stat[2] = tx_en_q;
    stat[3] = tx_empty;
    isr     = '0;
    isr[0]  = tx_en_q;
    isr[1]  = mode_q[0][RXINT_SEL_BIT] ? rx_full : rx_any;
    isr[2]  = dbrk_q;
  end

  assign irq_o = |(isr & imask_q);

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      AW'(OFS_MODE): reg_rdata_o = mode_q[ptr_q];
      AW'(OFS_STAT): reg_rdata_o = stat;
      AW'(OFS_DATA): reg_rdata_o = rx_any ? head : '0;
      AW'(OFS_INT):  reg_rdata_o = isr;
      default:       reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/uart_regfront_chk.sv
`timescale 1ns/1ps
module uart_regfront_chk #(
  parameter int DEPTH = 4,
  parameter int AW    = 5,
  parameter int CNT_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             we_i,
  input logic             re_i,
  input logic [AW-1:0]    addr_i,
  input logic [4:0]       cmd_i,
  input logic             rx_valid_i,
  input logic             rx_ready_i,
  input logic             brk_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             ptr_i,
  input logic             tx_en_i,
  input logic             txemp_i,
  input logic             dbrk_i,
  input logic             tx_valid_i
);
  AST_PTR_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == AW'('h00)) |=> ptr_i); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= CNT_W'(DEPTH)); // R4
  AST_REFUSED_NO_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && !rx_ready_i && !brk_i && !re_i && !we_i) |=> $stable(cnt_i)); // R5
  AST_TX_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == AW'('h08) && cmd_i[4:2] == 3'd3 && cmd_i[1:0] != 2'd1)
      |=> (!tx_en_i && txemp_i)); // R6
  AST_SENT_LEAVES_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_i |-> txemp_i); // R7
  AST_BREAK_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_i |=> dbrk_i); // R9
endmodule

bind uart_regfront uart_regfront_chk #(.DEPTH(DEPTH), .AW(AW), .CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .we_i       (reg_we_i),
  .re_i       (reg_re_i),
  .addr_i     (reg_addr_i),
  .cmd_i      (reg_wdata_i[6:2]),
  .rx_valid_i (rx_valid_i),
  .rx_ready_i (rx_ready_o),
  .brk_i      (brk_i),
  .cnt_i      (rx_cnt),
  .ptr_i      (ptr_q),
  .tx_en_i    (tx_en_q),
  .txemp_i    (tx_empty),
  .dbrk_i     (dbrk_q),
  .tx_valid_i (tx_valid_o)
);

// File: tb/sim_uart_regfront.sv
`timescale 1ns/1ps
module sim_uart_regfront;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       we = 0, re = 0, rx_valid = 0, brk = 0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0, rx_data = '0;
  logic [7:0] rdata, tx_data;
  logic       rx_ready, tx_valid, irq;

  always #2.5 clk = ~clk;

  uart_regfront u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_re_i(re),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_ready_o(rx_ready),
    .brk_i(brk), .tx_valid_o(tx_valid), .tx_data_o(tx_data), .irq_o(irq)
  );

  // behavioural reference
  logic [7:0] m_mr [2];
  int         m_ptr;
  bit         m_txen, m_rxen, m_txemp, m_db, m_txv;
  logic [7:0] m_tb, m_imr;
  logic [7:0] q [$];
  int         n_chk = 0, n_fail = 0;

  function automatic logic [7:0] m_stat();
    return {4'b0, m_txemp, m_txen, q.size() == 4, q.size() != 0};
  endfunction
  function automatic logic [7:0] m_isr();
    logic rxi;
    rxi = m_mr[0][6] ? (q.size() == 4) : (q.size() != 0);
    return {5'b0, m_db, rxi, m_txen};
  endfunction
  function automatic logic [7:0] m_read(input logic [4:0] a);
    case (a)
      5'h00:   return m_mr[m_ptr];
      5'h04:   return m_stat();
      5'h0C:   return (q.size() != 0) ? q[0] : 8'h00;
      5'h14:   return m_isr();
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mr[0] = 0; m_mr[1] = 0; m_ptr = 0; m_txen = 0; m_rxen = 0;
      m_txemp = 1; m_db = 0; m_txv = 0; m_tb = 0; m_imr = 0; q.delete();
    end else begin
      int  pre;
      bit  acc;
      pre = q.size();
      acc = m_rxen && pre < 4;
      m_txv = 0;
      if (re && addr == 5'h0C && pre != 0) void'(q.pop_front());
      if (brk) begin
        m_db = 1;
        if (q.size() == 4) q[3] = 8'h00; else q.push_back(8'h00);
      end else if (rx_valid && acc) q.push_back(rx_data);
      if (we) begin
        case (addr)
          5'h00: begin m_mr[m_ptr] = wdata; m_ptr = 1; end
          5'h08: begin
            case (wdata[6:4])
              3'd1: m_ptr = 0;
              3'd2: begin m_rxen = 0; q.delete(); end
              3'd3: begin m_txen = 0; m_txemp = 1; end
              3'd5: m_db = 0;
              default: ;
            endcase
            if (wdata[3:2] == 2'd1) begin
              m_txen = 1;
              if (!m_txemp) begin m_txv = 1; m_txemp = 1; end
            end else if (wdata[3:2] == 2'd2) m_txen = 0;
            if (wdata[1:0] == 2'd1) m_rxen = 1;
            else if (wdata[1:0] == 2'd2) m_rxen = 0;
          end
          5'h0C: begin
            m_tb = wdata; m_txemp = 0;
            if (m_txen) begin m_txv = 1; m_txemp = 1; end
          end
          5'h14: m_imr = wdata;
          default: ;
        endcase
      end
    end
  end

  // per-clock comparison of the free-running outputs
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R8 irq_o", {7'b0, irq}, {7'b0, |(m_isr() & m_imr)});
      chk("R3 rx_ready_o", {7'b0, rx_ready}, {7'b0, m_rxen && q.size() < 4});
      chk("R7 tx_valid_o", {7'b0, tx_valid}, {7'b0, m_txv});
      if (m_txv) chk("R7 tx_data_o", tx_data, m_tb);
    end
  end

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    we = 1; addr = a; wdata = d;
    @(negedge clk);
    we = 0;
  endtask
  task automatic rd(input logic [4:0] a, input string tag);
    addr = a; re = 1;
    #1 chk(tag, rdata, m_read(a));
    @(negedge clk);
    re = 0;
  endtask
  task automatic rx(input logic [7:0] d);
    rx_valid = 1; rx_data = d;
    @(negedge clk);
    rx_valid = 0;
  endtask
  task automatic brk_ev();
    brk = 1;
    @(negedge clk);
    brk = 0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 status", rdata, rdata); n_chk--;
    rd(5'h04, "R1 status after reset");
    rd(5'h14, "R1 flags after reset");
    rd(5'h00, "R1 mode after reset");
    // R2 pointer
    wr(5'h00, 8'h40); wr(5'h00, 8'h13);
    rd(5'h00, "R2 second mode reg");
    wr(5'h00, 8'h55);
    rd(5'h00, "R2 stays on second");
    wr(5'h08, 8'h10);
    rd(5'h00, "R2 pointer reset");
    wr(5'h00, 8'h00);
    rd(5'h00, "R2 after rewrite");
    // R3 enable both
    wr(5'h08, 8'h05);
    rd(5'h04, "R3 status enabled");
    // R4 FIFO order
    rx(8'hA1); rx(8'hB2); rx(8'hC3);
    rd(5'h04, "R4 status nonempty");
    rd(5'h0C, "R4 pop oldest");
    rx(8'hD4); rx(8'hE5);
    rd(5'h04, "R4 status full");
    rx(8'hF6); // R5 refused
    rd(5'h04, "R5 still full");
    for (int i = 0; i < 4; i++) rd(5'h0C, "R4/R5 pop order");
    rd(5'h0C, "R4 empty read zero");
    rd(5'h04, "R4 status empty");
    // R9 break overwrite
    rx(8'h11); rx(8'h22); rx(8'h33); rx(8'h44);
    brk_ev();
    rd(5'h14, "R9 break flag");
    for (int i = 0; i < 4; i++) rd(5'h0C, "R9 zero replaces newest");
    wr(5'h08, 8'h50);
    rd(5'h14, "R9 break flag cleared");
    // R6 receiver reset
    rx(8'h77); rx(8'h88);
    wr(5'h08, 8'h20);
    rd(5'h04, "R6 rx reset flush");
    rx(8'h99); // R5 disabled receiver
    rd(5'h04, "R5 disabled ignores");
    brk_ev();
    rd(5'h0C, "R9 break while disabled");
    wr(5'h08, 8'h50);
    // R7 transmit
    wr(5'h0C, 8'h5A);
    rd(5'h04, "R7 empty after send");
    wr(5'h08, 8'h08);
    wr(5'h0C, 8'h66);
    rd(5'h04, "R7 held byte");
    wr(5'h08, 8'h04);
    rd(5'h04, "R7 enable sends held");
    wr(5'h08, 8'h30);
    rd(5'h04, "R6 tx reset");
    wr(5'h08, 8'h0F);
    rd(5'h04, "R3 reserved fields no effect");
    // R8 interrupts
    wr(5'h14, 8'h01);
    wr(5'h08, 8'h04);
    rd(5'h14, "R8 tx flag");
    wr(5'h08, 8'h10); wr(5'h00, 8'h40);
    wr(5'h08, 8'h01); wr(5'h14, 8'h02);
    rx(8'hC1);
    rd(5'h14, "R8 full-select not yet");
    rx(8'hC2); rx(8'hC3); rx(8'hC4);
    rd(5'h14, "R8 full-select set");
    rd(5'h0C, "R8 pop clears full");
    rd(5'h14, "R8 after pop");
    // R10 ignored writes
    wr(5'h04, 8'hFF); wr(5'h10, 8'hFF);
    rd(5'h04, "R10 status unchanged");
    rd(5'h10, "R10 unused reads zero");
    rd(5'h08, "R10 command reads zero");
    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule